// File: doc/BRIEF.md
# Interrupt Dispatch List Walker

This sequencer services pending interrupt levels by walking linked lists of device descriptors kept in word-addressed memory. The caller starts it with a pulse. It then picks the most urgent pending level and clears that level's event with a write. Next it reads the head pointer for that level from a vector table. For each descriptor in the chain it issues one handler request, which carries the descriptor address and the device type word, and it waits for the handler to acknowledge. When a chain ends, the pending vector is sampled again. Work continues until no level is pending, and then a one-cycle done pulse goes back to the caller.

Level 0 is the most urgent and level NLEVELS-1 the least. Levels 0 and 1 are meant to be taken as immediate traps, so finding either of them here is a fault. The walker halts instead of dispatching. A runaway guard caps the number of descriptors visited on one chain, which protects against a corrupted, circular list.

Top module: `irq_list_walker`

## Requirements
- R1: After reset, done_o, halt_o, rd_req_o, hreq_o and evw_valid_o are all low, and halt_cause_o is 0.
- R2: A start pulse while no level is pending produces a done_o pulse with no clear write, no read and no handler request.
- R3: Of the pending levels 2 to NLEVELS-1, the lowest-numbered one is serviced first. Its clear write carries that level on evw_level_o and has bit 0 of evw_data_o equal to 0. The write happens before any descriptor of that level is visited.
- R4: The head pointer is read at word address VEC_BASE + level. A head value of 0 means an empty chain: no descriptor is read and no handler request is made for that level.
- R5: For a descriptor at address P, word P+0 gives the next pointer and word P+1 gives the device type. One handler request then carries hdesc_addr_o = P and hdev_type_o = the type word, and it stays asserted with a stable address until hack_i.
- R6: The walker moves to the next descriptor only after the handler acknowledge. The chain is followed through word 0, and a next pointer of 0 ends it.
- R7: After each chain the pending vector is sampled again. Any pending level, including one raised during handling, is serviced before done_o.
- R8: If level 0 or level 1 is the most urgent pending level, halt_o rises with halt_cause_o = 1 and no clear write takes place. halt_o then stays high with no further requests and no done_o until reset.
- R9: If a chain would have its (MAX_VISITS+1)-th descriptor visited, halt_o rises with halt_cause_o = 2 after exactly MAX_VISITS handler requests on that chain.
- R10: start_i is ignored while a dispatch is in progress, so one dispatch produces exactly one done_o pulse.
- R11: done_o is high for exactly one cycle.
- R12: A read request holds rd_req_o and rd_addr_o until rd_gnt_i. Data is accepted on a later rd_rvalid_i, after any latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a dispatch (honoured only when idle) |
| done_o | output | 1 | One-cycle completion pulse |
| pending_i | input | NLEVELS | Pending event per level, bit 0 most urgent |
| evw_valid_o | output | 1 | Event clear write request |
| evw_ready_i | input | 1 | Clear write accepted |
| evw_level_o | output | $clog2(NLEVELS) | Level whose event is cleared |
| evw_data_o | output | DW | Clear data word (bit 0 = 0) |
| rd_req_o | output | 1 | Memory read request |
| rd_gnt_i | input | 1 | Read request accepted |
| rd_addr_o | output | AW | Read word address |
| rd_rvalid_i | input | 1 | Read data valid |
| rd_data_i | input | DW | Read data |
| hreq_o | output | 1 | Handler request |
| hack_i | input | 1 | Handler finished |
| hdesc_addr_o | output | AW | Descriptor address for the handler |
| hdev_type_o | output | DW | Device type word for the handler |
| halt_o | output | 1 | Machine halt |
| halt_cause_o | output | 2 | 0 none, 1 trap level polled, 2 runaway chain |

## Verification
The bench builds the walker with an 8-bit address, 16 levels, a vector table at word 0xF0 and MAX_VISITS of 4. The small visit limit lets a two-descriptor circular chain trip the runaway guard within a few dozen cycles. The high table base shows that the head address is formed from the base plus the level and not from the level alone. The memory and the handler answer with pseudo-random delays, so the holding of each request and the variable read latency are both exercised.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL,
    ST_CLEAR,
    ST_VEC_REQ,
    ST_VEC_WAIT,
    ST_VISIT,
    ST_NEXT_REQ,
    ST_NEXT_WAIT,
    ST_TYPE_REQ,
    ST_TYPE_WAIT,
    ST_HANDLE,
    ST_HALT
  } walk_state_e;

  typedef enum logic [1:0] {
    HC_NONE    = 2'd0,
    HC_TRAPLVL = 2'd1,
    HC_RUNAWAY = 2'd2
  } halt_cause_e;

  localparam int unsigned TRAP_LEVELS = 2;

endpackage

// File: rtl/irqw_level_pick.sv
module irqw_level_pick #(
  parameter int unsigned NLEVELS = 16,
  localparam int unsigned LW = $clog2(NLEVELS)
) (
  input  logic [NLEVELS-1:0] pending_i,
  output logic               any_o,
  output logic [LW-1:0]      level_o
);

  always_comb begin
    level_o = '0;
    for (int i = NLEVELS - 1; i >= 0; i--) begin
      if (pending_i[i]) level_o = LW'(i);
    end
    any_o = |pending_i;
  end

endmodule

// File: rtl/irqw_visit_guard.sv
module irqw_visit_guard #(
  parameter int unsigned MAX_VISITS = 1024,
  localparam int unsigned CW = $clog2(MAX_VISITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic limit_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign limit_o = (cnt_q >= CW'(MAX_VISITS));

endmodule

// File: rtl/irq_list_walker.sv
module irq_list_walker
  import irqw_pkg::*;
#(
  parameter int unsigned    NLEVELS    = 16,
  parameter int unsigned    AW         = 24,
  parameter int unsigned    DW         = 32,
  parameter int unsigned    MAX_VISITS = 1024,
  parameter logic [AW-1:0]  VEC_BASE   = '0,
  localparam int unsigned   LW         = $clog2(NLEVELS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic               done_o,
  input  logic [NLEVELS-1:0] pending_i,
  output logic               evw_valid_o,
  input  logic               evw_ready_i,
  output logic [LW-1:0]      evw_level_o,
  output logic [DW-1:0]      evw_data_o,
  output logic               rd_req_o,
  input  logic               rd_gnt_i,
  output logic [AW-1:0]      rd_addr_o,
  input  logic               rd_rvalid_i,
  input  logic [DW-1:0]      rd_data_i,
  output logic               hreq_o,
  input  logic               hack_i,
  output logic [AW-1:0]      hdesc_addr_o,
  output logic [DW-1:0]      hdev_type_o,
  output logic               halt_o,
  output logic [1:0]         halt_cause_o
);

  walk_state_e state_q, state_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] nxt_q, nxt_d;
  logic [DW-1:0] typ_q, typ_d;
  halt_cause_e   cause_q, cause_d;
  logic          done_q, done_d;

  logic          any_pend;
  logic [LW-1:0] top_lvl;
  logic          guard_clr, guard_inc, guard_limit;
  logic [AW-1:0] rd_ptr;

  irqw_level_pick #(.NLEVELS(NLEVELS)) u_pick (
    .pending_i (pending_i),
    .any_o     (any_pend),
    .level_o   (top_lvl)
  );

  irqw_visit_guard #(.MAX_VISITS(MAX_VISITS)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (guard_clr),
    .inc_i   (guard_inc),
    .limit_o (guard_limit)
  );

  assign rd_ptr = rd_data_i[AW-1:0];

  // next-state
  always_comb begin
    state_d   = state_q;
    lvl_d     = lvl_q;
    cur_d     = cur_q;
    nxt_d     = nxt_q;
    typ_d     = typ_q;
    cause_d   = cause_q;
    done_d    = 1'b0;
    guard_clr = 1'b0;
    guard_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) state_d = ST_POLL;
      end
      ST_POLL: begin
        if (!any_pend) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (top_lvl < LW'(TRAP_LEVELS)) begin
          cause_d = HC_TRAPLVL;
          state_d = ST_HALT;
        end else begin
          lvl_d   = top_lvl;
          state_d = ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        if (evw_ready_i) state_d = ST_VEC_REQ;
      end
      ST_VEC_REQ: begin
        if (rd_gnt_i) state_d = ST_VEC_WAIT;
      end
      ST_VEC_WAIT: begin
        if (rd_rvalid_i) begin
          guard_clr = 1'b1;
          cur_d     = rd_ptr;
          state_d   = (rd_ptr == '0) ? ST_POLL : ST_VISIT;
        end
      end
      ST_VISIT: begin
        if (guard_limit) begin
          cause_d = HC_RUNAWAY;
          state_d = ST_HALT;
        end else begin
          guard_inc = 1'b1;
          state_d   = ST_NEXT_REQ;
        end
      end
      ST_NEXT_REQ: begin
        if (rd_gnt_i) state_d = ST_NEXT_WAIT;
      end
      ST_NEXT_WAIT: begin
        if (rd_rvalid_i) begin
          nxt_d   = rd_ptr;
          state_d = ST_TYPE_REQ;
        end
      end
      ST_TYPE_REQ: begin
        if (rd_gnt_i) state_d = ST_TYPE_WAIT;
      end
      ST_TYPE_WAIT: begin
        if (rd_rvalid_i) begin
          typ_d   = rd_data_i;
          state_d = ST_HANDLE;
        end
      end
      ST_HANDLE: begin
        if (hack_i) begin
          if (nxt_q == '0) begin
            state_d = ST_POLL;
          end else begin
            cur_d   = nxt_q;
            state_d = ST_VISIT;
          end
        end
      end
      ST_HALT: begin
        state_d = ST_HALT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      cur_q   <= '0;
      nxt_q   <= '0;
      typ_q   <= '0;
      cause_q <= HC_NONE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      cur_q   <= cur_d;
      nxt_q   <= nxt_d;
      typ_q   <= typ_d;
      cause_q <= cause_d;
      done_q  <= done_d;
    end
  end

  // outputs
  always_comb begin
    rd_req_o  = 1'b0;
    rd_addr_o = '0;
    unique case (state_q)
      ST_VEC_REQ: begin
        rd_req_o  = 1'b1;
        rd_addr_o = VEC_BASE + AW'(lvl_q);
      end
      ST_NEXT_REQ: begin
        rd_req_o  = 1'b1;
        rd_addr_o = cur_q;
      end
      ST_TYPE_REQ: begin
        rd_req_o  = 1'b1;
        rd_addr_o = cur_q + AW'(1);
      end
      default: ;
    endcase
  end

  assign evw_valid_o  = (state_q == ST_CLEAR);
  assign evw_level_o  = lvl_q;
  assign evw_data_o   = '0;
  assign hreq_o       = (state_q == ST_HANDLE);
  assign hdesc_addr_o = cur_q;
  assign hdev_type_o  = typ_q;
  assign halt_o       = (state_q == ST_HALT);
  assign halt_cause_o = cause_q;
  assign done_o       = done_q;

endmodule

// File: rtl/irqw_checker.sv
module irqw_checker #(
  parameter int unsigned AW = 24,
  parameter int unsigned LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done_o,
  input logic          halt_o,
  input logic [1:0]    halt_cause_o,
  input logic          rd_req_o,
  input logic          rd_gnt_i,
  input logic [AW-1:0] rd_addr_o,
  input logic          hreq_o,
  input logic          hack_i,
  input logic [AW-1:0] hdesc_addr_o,
  input logic          evw_valid_o,
  input logic [LW-1:0] evw_level_o
);

  a_r1_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_o, hreq_o, evw_valid_o}));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o && $stable(halt_cause_o));

  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !(rd_req_o || hreq_o || evw_valid_o || done_o));

  a_r9_halt_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (halt_cause_o == 2'd1 || halt_cause_o == 2'd2));

  a_r5_hreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq_o && !hack_i) |=> (hreq_o && $stable(hdesc_addr_o)));

  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_gnt_i) |=> (rd_req_o && $stable(rd_addr_o)));

  a_r3_clear_level: assert property (@(posedge clk) disable iff (!rst_n)
    evw_valid_o |-> (evw_level_o >= LW'(2)));

endmodule

bind irq_list_walker irqw_checker #(.AW(AW), .LW(LW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .done_o       (done_o),
  .halt_o       (halt_o),
  .halt_cause_o (halt_cause_o),
  .rd_req_o     (rd_req_o),
  .rd_gnt_i     (rd_gnt_i),
  .rd_addr_o    (rd_addr_o),
  .hreq_o       (hreq_o),
  .hack_i       (hack_i),
  .hdesc_addr_o (hdesc_addr_o),
  .evw_valid_o  (evw_valid_o),
  .evw_level_o  (evw_level_o)
);

// File: tb/tb_irq_list_walker.sv
`timescale 1ns/1ps
module tb_irq_list_walker;
  localparam int NL = 16;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int LW = 4;
  localparam int MAXV = 4;
  localparam logic [AW-1:0] VBASE = 8'hF0;

  localparam logic [3:0] K_CLR = 4'd1, K_HND = 4'd2, K_DONE = 4'd3;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic done_o;
  logic [NL-1:0] pend;
  logic evw_valid_o, evw_ready_i;
  logic [LW-1:0] evw_level_o;
  logic [DW-1:0] evw_data_o;
  logic rd_req_o, rd_gnt_i, rd_rvalid_i;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_i;
  logic hreq_o, hack_i;
  logic [AW-1:0] hdesc_addr_o;
  logic [DW-1:0] hdev_type_o;
  logic halt_o;
  logic [1:0] halt_cause_o;

  always #2.5 clk = ~clk;

  irq_list_walker #(.NLEVELS(NL), .AW(AW), .DW(DW), .MAX_VISITS(MAXV), .VEC_BASE(VBASE)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .pending_i(pend),
    .evw_valid_o(evw_valid_o), .evw_ready_i(evw_ready_i), .evw_level_o(evw_level_o),
    .evw_data_o(evw_data_o), .rd_req_o(rd_req_o), .rd_gnt_i(rd_gnt_i), .rd_addr_o(rd_addr_o),
    .rd_rvalid_i(rd_rvalid_i), .rd_data_i(rd_data_i), .hreq_o(hreq_o), .hack_i(hack_i),
    .hdesc_addr_o(hdesc_addr_o), .hdev_type_o(hdev_type_o), .halt_o(halt_o),
    .halt_cause_o(halt_cause_o));

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  logic done_prev = 1'b0;

  logic [DW-1:0] mem [256];
  logic [NL-1:0] post_mask = '0;
  logic [DW-1:0] raise_type = '1;
  logic [NL-1:0] raise_mask = '0;
  logic [63:0] expq [$];

  // environment models
  logic [7:0] lfsr;
  logic in_flight;
  logic [1:0] lat;
  logic [AW-1:0] addr_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= 8'hA5; rd_gnt_i <= 1'b0; rd_rvalid_i <= 1'b0; rd_data_i <= '0;
      in_flight <= 1'b0; lat <= '0; addr_q <= '0; hack_i <= 1'b0;
      evw_ready_i <= 1'b0; pend <= '0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rd_gnt_i <= lfsr[0] | lfsr[1];
      evw_ready_i <= lfsr[2] | lfsr[6];
      rd_rvalid_i <= 1'b0;
      if (rd_req_o && rd_gnt_i) begin
        in_flight <= 1'b1; addr_q <= rd_addr_o; lat <= lfsr[4:3];
      end else if (in_flight) begin
        if (lat == 2'd0) begin
          rd_rvalid_i <= 1'b1; rd_data_i <= mem[addr_q]; in_flight <= 1'b0;
        end else lat <= lat - 2'd1;
      end
      hack_i <= hreq_o && !hack_i && lfsr[5];
      pend <= (pend & ~((evw_valid_o && evw_ready_i) ? (NL'(1) << evw_level_o) : '0))
              | post_mask
              | ((hreq_o && hack_i && hdev_type_o == raise_type) ? raise_mask : '0);
    end
  end

  task automatic fail(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    errors++;
    $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) fail(req, what, act, exp);
  endtask

  // driver-side expectation pushers
  task automatic exp_clr(input int lvl);  expq.push_back({K_CLR, 12'd0, 16'(lvl), 32'd0}); endtask
  task automatic exp_hnd(input logic [AW-1:0] a, input logic [DW-1:0] t);
    expq.push_back({K_HND, 12'd0, 16'(a), t});
  endtask
  task automatic exp_done(); expq.push_back({K_DONE, 60'd0}); endtask

  // monitor
  task automatic compare(input logic [63:0] got);
    checks++;
    if (expq.size() == 0) fail("R3-R7", "unexpected event", got, 64'd0);
    else begin
      logic [63:0] e;
      e = expq.pop_front();
      if (e !== got) fail("R3-R7 sequence", "event", got, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (evw_valid_o && evw_ready_i) begin
        compare({K_CLR, 12'd0, 16'(evw_level_o), 32'd0});
        chk("R3", "clear bit0", 64'(evw_data_o[0]), 64'd0);
      end
      if (hreq_o && hack_i) compare({K_HND, 12'd0, 16'(hdesc_addr_o), hdev_type_o});
      if (done_o) begin
        compare({K_DONE, 60'd0});
        done_cnt++;
        chk("R11", "done width", 64'(done_prev), 64'd0);
      end
      done_prev <= done_o;
    end else done_prev <= 1'b0;
  end

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic desc(input logic [AW-1:0] a, input logic [AW-1:0] nx, input logic [DW-1:0] t);
    mem[a] = DW'(nx); mem[a + 1] = t;
  endtask

  task automatic post(input logic [NL-1:0] m);
    @(negedge clk); post_mask = m; @(negedge clk); post_mask = '0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_end(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done_o || halt_o) break;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; start_i = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d0;
    rst_n = 1'b0; start_i = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R1 reset state
    chk("R1", "done", 64'(done_o), 0);
    chk("R1", "halt", 64'(halt_o), 0);
    chk("R1", "requests", 64'({rd_req_o, hreq_o, evw_valid_o}), 0);
    chk("R1", "cause", 64'(halt_cause_o), 0);

    // R2 nothing pending
    exp_done();
    pulse_start(); wait_end(50); repeat (3) @(negedge clk);
    chk("R2", "queue drained", 64'(expq.size()), 0);

    // R3 R4 R5 R6 R7: three levels, one empty chain
    clear_mem();
    mem[VBASE + 5]  = 32'h20; desc(8'h20, 8'h24, 32'h105); desc(8'h24, 8'h28, 32'h205); desc(8'h28, 8'h00, 32'h305);
    mem[VBASE + 9]  = 32'h00;
    mem[VBASE + 12] = 32'h30; desc(8'h30, 8'h00, 32'h10C);
    mem[8'h05] = 32'hDEAD; mem[8'h0C] = 32'hBEEF;  // R4 decoys at level-only addresses
    exp_clr(5); exp_hnd(8'h20, 32'h105); exp_hnd(8'h24, 32'h205); exp_hnd(8'h28, 32'h305);
    exp_clr(9); exp_clr(12); exp_hnd(8'h30, 32'h10C); exp_done();
    post(16'h1220);
    pulse_start(); wait_end(2000); repeat (3) @(negedge clk);
    chk("R6", "queue drained", 64'(expq.size()), 0);
    chk("R7", "pending empty", 64'(pend), 0);

    // R7 level raised during handling, R10 start ignored while busy
    clear_mem();
    mem[VBASE + 7] = 32'h60; desc(8'h60, 8'h00, 32'h77);
    mem[VBASE + 3] = 32'h64; desc(8'h64, 8'h68, 32'h31); desc(8'h68, 8'h00, 32'h32);
    raise_type = 32'h77; raise_mask = 16'h0008;
    exp_clr(7); exp_hnd(8'h60, 32'h77); exp_clr(3); exp_hnd(8'h64, 32'h31); exp_hnd(8'h68, 32'h32); exp_done();
    d0 = done_cnt;
    post(16'h0080);
    pulse_start();
    repeat (6) pulse_start();  // R10: extra starts mid-dispatch
    wait_end(2000); repeat (40) @(negedge clk);
    chk("R10", "single done", 64'(done_cnt - d0), 1);
    chk("R7", "queue drained", 64'(expq.size()), 0);
    raise_mask = '0; raise_type = '1;

    // R9 circular chain
    clear_mem();
    mem[VBASE + 4] = 32'h40; desc(8'h40, 8'h50, 32'hAA); desc(8'h50, 8'h40, 32'hBB);
    exp_clr(4); exp_hnd(8'h40, 32'hAA); exp_hnd(8'h50, 32'hBB); exp_hnd(8'h40, 32'hAA); exp_hnd(8'h50, 32'hBB);
    d0 = done_cnt;
    post(16'h0010);
    pulse_start(); wait_end(2000); repeat (20) @(negedge clk);
    chk("R9", "halt", 64'(halt_o), 1);
    chk("R9", "cause", 64'(halt_cause_o), 2);
    chk("R9", "visits", 64'(expq.size()), 0);
    chk("R8", "no done in halt", 64'(done_cnt - d0), 0);
    do_reset();
    chk("R1", "halt cleared", 64'(halt_o), 0);

    // R8 trap levels
    clear_mem();
    mem[VBASE + 6] = 32'h70; desc(8'h70, 8'h00, 32'h66);
    post(16'h0042);
    pulse_start(); wait_end(200); repeat (10) @(negedge clk);
    chk("R8", "halt lvl1", 64'(halt_o), 1);
    chk("R8", "cause lvl1", 64'(halt_cause_o), 1);
    chk("R8", "no clear", 64'(pend), 64'h0042);
    chk("R8", "quiet", 64'({rd_req_o, hreq_o, evw_valid_o}), 0);
    do_reset();
    post(16'h0001);
    pulse_start(); wait_end(200); repeat (5) @(negedge clk);
    chk("R8", "halt lvl0", 64'(halt_o), 1);
    chk("R8", "cause lvl0", 64'(halt_cause_o), 1);
    chk("R8", "no events", 64'(expq.size()), 0);

    finish_run();
  end
endmodule